// File: doc/BRIEF.md
# Multi-format RGB pixel input unpacker

This block sits at the front of a graphics capture path. It takes the raw pixel inputs of a graphics controller: three 8-bit colour buses, horizontal sync and vertical sync, all sampled on the pixel clock. It turns them into one normalized 24-bit RGB888 pixel per clock, with a valid strobe and syncs kept in step with the pixels. A 2-bit format select tells the block how the source is wired:
- straight 24-bit colour;
- a 16-bit 5-6-5 word spread over the green and blue buses;
- an 8-bit double-rate stream on the blue bus, where each pixel arrives as two bytes on opposite edges of one pixel clock.

Narrow 5-bit and 6-bit channels are widened to 8 bits by repeating their top bits. A new format select only takes hold when vertical sync starts, so a frame never mixes two packings. Every format passes through the same two register stages. Output pixels and syncs therefore come out exactly two rising edges after the inputs were sampled.

Top module: `rgb_unpacker`

## Requirements
- R1: While rst_ni is low, red_o, green_o, blue_o, hsync_o, vsync_o and valid_o are all 0.
- R2: After reset is released, valid_o is 0 after the first rising edge, goes to 1 at the second rising edge, and then stays at 1.
- R3: Format 2'b00: the output colours equal red_i, green_i and blue_i as sampled two rising edges earlier.
- R4: Format 2'b11: a 16-bit word is formed with green_i as bits 15..8 and blue_i as bits 7..0. The word is split as red = bits 15..11, green = bits 10..5 and blue = bits 4..0.
- R5: Format 2'b01: blue_i sampled on a rising edge forms word bits 7..0. blue_i sampled on the following falling edge forms bits 15..8. The word is split and expanded as in R4 and R6, and appears on the outputs after the next rising edge.
- R6: A 5-bit field f expands to {f, f[4:2]}. A 6-bit field f expands to {f, f[5:4]}.
- R7: Format 2'b10 behaves exactly like format 2'b00.
- R8: hsync_o and vsync_o equal hsync_i and vsync_i as sampled two rising edges earlier, the same delay as the pixel data.
- R9: The active format is 2'b00 after reset. It changes only on a rising edge where vsync_i is sampled high after being sampled low (or after reset). In that case it takes fmt_sel_i, and the new format already applies to the pixel sampled on that edge.
- R10: A 5-6-5 source wired to the top bits of the 24-bit buses, with the low bits at 0, passes through unchanged in format 2'b00. The low bits of each output channel stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_sel_i | input | 2 | Requested input format: 00 RGB888, 01 double-rate byte, 10 reserved (RGB888), 11 RGB565 |
| red_i | input | 8 | Red input bus |
| green_i | input | 8 | Green input bus (upper word byte in RGB565) |
| blue_i | input | 8 | Blue input bus (lower word byte, or the double-rate byte stream) |
| hsync_i | input | 1 | Horizontal sync input |
| vsync_i | input | 1 | Vertical sync input |
| red_o | output | 8 | Normalized red |
| green_o | output | 8 | Normalized green |
| blue_o | output | 8 | Normalized blue |
| hsync_o | output | 1 | Horizontal sync aligned with the pixel output |
| vsync_o | output | 1 | Vertical sync aligned with the pixel output |
| valid_o | output | 1 | Output pixel valid |

## Verification
The bench builds the block with its default parameters: 8-bit channels and a 5-6-5 field split. At these values all three physical packings and both expansion widths (5 to 8 and 6 to 8) can be compared bit for bit against the bench's own model. The stimulus includes extreme byte pairs in the double-rate format, where the falling-edge byte differs completely from the rising-edge byte. It also changes the format select while vertical sync is held, to check that the active format waits for the next frame start.

// File: rtl/rgb_unpack_pkg.sv
`timescale 1ns/1ps
package rgb_unpack_pkg;
  typedef enum logic [1:0] {
    FMT_RGB888 = 2'b00,
    FMT_DDR8   = 2'b01,
    FMT_RSVD   = 2'b10,
    FMT_RGB565 = 2'b11
  } in_fmt_e;
endpackage

// File: rtl/fmt_tracker.sv
`timescale 1ns/1ps
module fmt_tracker
  import rgb_unpack_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     vsync_i,
  input  logic [1:0] fmt_sel_i,
  output in_fmt_e  fmt_o
);
  logic    vs_q;
  in_fmt_e fmt_eff;

  // frame start: new format applies to the pixel sampled on this edge
  assign fmt_eff = (vsync_i && !vs_q) ? in_fmt_e'(fmt_sel_i) : fmt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q  <= 1'b0;
      fmt_o <= FMT_RGB888;
    end else begin
      vs_q  <= vsync_i;
      fmt_o <= fmt_eff;
    end
  end
endmodule

// File: rtl/ddr_byte_capture.sv
`timescale 1ns/1ps
module ddr_byte_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] byte_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byte_o <= '0;
    else         byte_o <= byte_i;
  end
endmodule

// File: rtl/chan_expand.sv
`timescale 1ns/1ps
module chan_expand #(
  parameter int SRC_W = 5,
  parameter int DST_W = 8
) (
  input  logic [SRC_W-1:0] src_i,
  output logic [DST_W-1:0] dst_o
);
  localparam int FILL_W = DST_W - SRC_W;
  generate
    if (FILL_W > 0) begin : g_rep
      assign dst_o = {src_i, src_i[SRC_W-1 -: FILL_W]};
    end else begin : g_trunc
      assign dst_o = src_i[SRC_W-1 -: DST_W];
    end
  endgenerate
endmodule

// File: rtl/rgb_unpacker.sv
`timescale 1ns/1ps
module rgb_unpacker
  import rgb_unpack_pkg::*;
#(
  parameter int CHAN_W = 8,
  parameter int R_W    = 5,
  parameter int G_W    = 6,
  parameter int B_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_sel_i,
  input  logic [CHAN_W-1:0] red_i,
  input  logic [CHAN_W-1:0] green_i,
  input  logic [CHAN_W-1:0] blue_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic [CHAN_W-1:0] red_o,
  output logic [CHAN_W-1:0] green_o,
  output logic [CHAN_W-1:0] blue_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              valid_o
);
  localparam int WORD_W = 2 * CHAN_W;

  in_fmt_e           fmt_act;
  logic [CHAN_W-1:0] s1_r, s1_g, s1_b, hi_q;
  logic              s1_hs, s1_vs, s1_vld;
  logic [WORD_W-1:0] word;
  logic [CHAN_W-1:0] xr, xg, xb;
  logic              packed_fmt;

  fmt_tracker u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vsync_i   (vsync_i),
    .fmt_sel_i (fmt_sel_i),
    .fmt_o     (fmt_act)
  );

  // upper byte of the double-rate pair, caught between two rising edges
  ddr_byte_capture #(.BYTE_W(CHAN_W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byte_i (blue_i),
    .byte_o (hi_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_r   <= '0;
      s1_g   <= '0;
      s1_b   <= '0;
      s1_hs  <= 1'b0;
      s1_vs  <= 1'b0;
      s1_vld <= 1'b0;
    end else begin
      s1_r   <= red_i;
      s1_g   <= green_i;
      s1_b   <= blue_i;
      s1_hs  <= hsync_i;
      s1_vs  <= vsync_i;
      s1_vld <= 1'b1;
    end
  end

  always_comb begin
    unique case (fmt_act)
      FMT_RGB565: word = {s1_g, s1_b};
      default:    word = {hi_q, s1_b};
    endcase
  end

  assign packed_fmt = (fmt_act == FMT_RGB565) || (fmt_act == FMT_DDR8);

  chan_expand #(.SRC_W(R_W), .DST_W(CHAN_W)) u_xr (
    .src_i (word[WORD_W-1 -: R_W]),
    .dst_o (xr)
  );
  chan_expand #(.SRC_W(G_W), .DST_W(CHAN_W)) u_xg (
    .src_i (word[B_W +: G_W]),
    .dst_o (xg)
  );
  chan_expand #(.SRC_W(B_W), .DST_W(CHAN_W)) u_xb (
    .src_i (word[B_W-1:0]),
    .dst_o (xb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_o   <= '0;
      green_o <= '0;
      blue_o  <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      red_o   <= packed_fmt ? xr : s1_r;
      green_o <= packed_fmt ? xg : s1_g;
      blue_o  <= packed_fmt ? xb : s1_b;
      hsync_o <= s1_hs;
      vsync_o <= s1_vs;
      valid_o <= s1_vld;
    end
  end
endmodule

// File: rtl/rgb_unpacker_chk.sv
`timescale 1ns/1ps
module rgb_unpacker_chk #(
  parameter int CHAN_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        fmt_sel_i,
  input logic [CHAN_W-1:0] red_i,
  input logic [CHAN_W-1:0] green_i,
  input logic [CHAN_W-1:0] blue_i,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic [CHAN_W-1:0] red_o,
  input logic [CHAN_W-1:0] green_o,
  input logic [CHAN_W-1:0] blue_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              valid_o,
  input logic [1:0]        fmt_act
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !hsync_o && !vsync_o &&
                 red_o == '0 && green_o == '0 && blue_o == '0));

  assert_valid_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  assert_pass_through_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fmt_act) == 2'b00) |->
      ({red_o, green_o, blue_o} == $past({red_i, green_i, blue_i}, 2)));

  assert_word_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fmt_act) == 2'b11) |->
      (red_o[7:3] == $past(green_i[7:3], 2) && blue_o[7:3] == $past(blue_i[4:0], 2)));

  assert_sync_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (hsync_o == $past(hsync_i, 2) && vsync_o == $past(vsync_i, 2)));

  assert_fmt_at_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_act != $past(fmt_act)) |-> ($past(vsync_i) && fmt_act == $past(fmt_sel_i)));
endmodule

bind rgb_unpacker rgb_unpacker_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fmt_sel_i (fmt_sel_i),
  .red_i     (red_i),
  .green_i   (green_i),
  .blue_i    (blue_i),
  .hsync_i   (hsync_i),
  .vsync_i   (vsync_i),
  .red_o     (red_o),
  .green_o   (green_o),
  .blue_o    (blue_o),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .valid_o   (valid_o),
  .fmt_act   (fmt_act)
);

// File: tb/rgb_unpacker_test.sv
`timescale 1ns/1ps
module rgb_unpacker_test;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] fmt_sel_i;
  logic [7:0] red_i, green_i, blue_i;
  logic       hsync_i, vsync_i;
  logic [7:0] red_o, green_o, blue_o;
  logic       hsync_o, vsync_o, valid_o;

  always #5 clk = ~clk;

  rgb_unpacker uut (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_sel_i(fmt_sel_i),
    .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .valid_o(valid_o)
  );

  int    n_chk = 0, n_err = 0, since_rst = 0;
  bit    done = 0;
  int    m_fmt = 0;
  bit    m_vsq = 0;
  int    e_pix = 0, e_fmt = 0;
  bit    e_hs = 0, e_vs = 0;
  string extra = "";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string fmt_tag(input int f);
    case (f)
      0: return "R3";
      2: return "R7";
      3: return "R4 R6";
      default: return "R5 R6";
    endcase
  endfunction

  function automatic int widen(input int v, input int w);
    return (v << (8 - w)) | (v >> (2 * w - 8));
  endfunction

  // enters at 3 ns before a rising edge, leaves at 3 ns before the next one
  task automatic cycle(input int r, input int g, input int lo, input int hi,
                       input bit hs, input bit vs, input int fmt);
    int word, npix, eff;
    red_i = r[7:0]; green_i = g[7:0]; blue_i = lo[7:0];
    hsync_i = hs; vsync_i = vs; fmt_sel_i = fmt[1:0];
    eff = (vs && !m_vsq) ? fmt : m_fmt;
    m_fmt = eff; m_vsq = vs;
    if (eff == 1 || eff == 3) begin
      word = (eff == 3) ? ((g << 8) | lo) : ((hi << 8) | lo);
      npix = (widen((word >> 11) & 31, 5) << 16) |
             (widen((word >> 5) & 63, 6) << 8) | widen(word & 31, 5);
    end else begin
      npix = (r << 16) | (g << 8) | lo;
    end
    @(posedge clk);
    since_rst++;
    #1;
    if (since_rst == 1) chk(valid_o == 1'b0, "R2 first edge", valid_o, 0);
    else if (since_rst >= 2) begin
      chk(valid_o == 1'b1, "R2 valid", valid_o, 1);
      chk({red_o, green_o, blue_o} == e_pix[23:0],
          {fmt_tag(e_fmt), " ", extra}, {red_o, green_o, blue_o}, e_pix);
      chk(hsync_o == e_hs && vsync_o == e_vs, "R8 sync",
          {hsync_o, vsync_o}, {e_hs, e_vs});
    end
    e_pix = npix; e_fmt = eff; e_hs = hs; e_vs = vs;
    #1 blue_i = hi[7:0];
    #5;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_fmt = 0; m_vsq = 0; since_rst = 0;
    #1;
    chk({red_o, green_o, blue_o} == 24'h0 && !valid_o && !hsync_o && !vsync_o,
        "R1 reset", {valid_o, hsync_o, vsync_o, red_o, green_o, blue_o}, 0);
    #19;
    rst_ni = 1'b1;
  endtask

  task automatic rnd_cycles(input int n, input int fmt, input bit vs);
    for (int i = 0; i < n; i++)
      cycle($urandom & 255, $urandom & 255, $urandom & 255, $urandom & 255,
            $urandom & 1, vs, fmt);
  endtask

  initial begin
    rst_ni = 1'b1; fmt_sel_i = 2'b00;
    red_i = 0; green_i = 0; blue_i = 0; hsync_i = 0; vsync_i = 0;
    #2;
    do_reset();
    // RGB888 from reset
    cycle(8'h12, 8'h34, 8'h56, 8'h00, 1, 1, 0);
    rnd_cycles(8, 0, 1);
    extra = "R10";
    for (int i = 0; i < 6; i++)
      cycle(($urandom & 31) << 3, ($urandom & 63) << 2, ($urandom & 31) << 3,
            $urandom & 255, i[0], 1, 0);
    // select changes while vsync held high: no effect yet
    extra = "R9";
    rnd_cycles(4, 3, 1);
    rnd_cycles(2, 3, 0);
    // frame start picks RGB565
    extra = "R9";
    rnd_cycles(1, 3, 1);
    extra = "";
    rnd_cycles(8, 3, 1);
    cycle(0, 8'hFF, 8'hFF, 0, 0, 1, 3);
    cycle(0, 8'h07, 8'hE0, 0, 1, 1, 3);
    // double-rate byte format
    rnd_cycles(1, 1, 0);
    extra = "R9";
    rnd_cycles(1, 1, 1);
    extra = "";
    rnd_cycles(10, 1, 1);
    cycle(0, 0, 8'h00, 8'hFF, 1, 1, 1);
    cycle(0, 0, 8'hFF, 8'h00, 0, 1, 1);
    cycle(0, 0, 8'h1F, 8'hF8, 1, 1, 1);
    // reserved code
    rnd_cycles(1, 2, 0);
    rnd_cycles(8, 2, 1);
    // reset in the middle of a run; vsync held low afterwards
    do_reset();
    extra = "R9";
    rnd_cycles(6, 3, 0);
    extra = "";
    rnd_cycles(1, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule